// File: doc/BRIEF.md
# Commit Squash Request Controller

This block sits in the commit stage of an out-of-order core. Every cycle, and for each hardware thread, it decides whether the reorder buffer starts a squash. It then produces the redirect broadcast that earlier pipeline stages consume. Three sources can ask for a squash:

- an internal trap timer, which expires a fixed number of cycles after a trap is raised;
- a thread-context request from outside the core;
- an execute-stage request that carries a sequence number, an include-self flag, mispredict and taken flags, and a redirect target.

The block keeps, for each thread, the sequence number of the youngest instruction it has placed in the reorder buffer. Execute-stage squashes aimed at anything younger are dropped, so a late squash from a younger branch cannot override one from an older branch. The controller also gates the insertion of renamed instructions: a thread that is squashing or waiting on a trap takes no new entries. The reorder-buffer walk and the trap handling itself happen elsewhere. This block sees only the head sequence number, the empty flag and a squash-done flag for each thread.

All outputs are registered, so each reflects the inputs sampled at the previous rising edge. Sequence numbers are compared as plain unsigned values.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After synchronous reset, every thread reads state 0 (running) on `thr_state`, and all squash, broadcast, insert and conflict outputs are 0.
- R2: An execute-stage squash has no effect when its sequence number is greater than the thread's youngest-inserted number, or when the thread is in state 2 (trap pending): no broadcast, and the state is unchanged.
- R3: The squash boundary of an accepted execute-stage squash equals the request's sequence number, or that number minus one when include-self is set.
- R4: On an accepted squash, the thread moves to state 1 (reorder-buffer squashing) and its youngest-inserted number takes the boundary value. For one cycle `rob_sq_vld` pulses with `rob_sq_bound` equal to the boundary.
- R5: An execute-stage broadcast carries the boundary as the done number, squash=1, ROB-squashing=1, the mispredict and taken flags, and the request's PC, next PC and micro-PC.
- R6: A squash-all (trap or thread-context) uses head sequence minus one as the boundary, or 0 when the ROB is empty. It clears the youngest-inserted number to 0, drives mispredict and taken as 0, and redirects to the thread's commit PC, next PC and micro-PC.
- R7: While a thread is in state 1 and the ROB does not report squash done, the ROB-squashing flag is re-sent every cycle. The cycle after squash done, the thread returns to state 0 and the flag drops.
- R8: A renamed instruction (thread id, sequence number) is written to the ROB one cycle later only if it is not marked squashed and its thread is in state 0. It is also not written when that thread starts a squash or trap in the same cycle. Each write updates the thread's youngest-inserted number.
- R9: A trap raised on a running thread moves it to state 2 on the next edge. A squash-all for that thread follows exactly TRAP_LAT edges after the trap was sampled.
- R10: When the trap timer expires while a thread-context request is pending, the trap squash is performed and `sq_conflict` is raised for that cycle. The thread-context squash is performed on the next edge.
- R11: When a squash-all and an execute-stage squash fall on the same thread in the same cycle, only the squash-all is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_gen | input | NUM_THR | Trap raised on a thread; starts its trap timer |
| tc_sq_req | input | NUM_THR | Thread-context squash request (held pending until served) |
| ex_sq_vld | input | NUM_THR | Execute-stage squash request |
| ex_sq_seq | input | NUM_THR*SEQ_W | Sequence number of the squashing instruction |
| ex_sq_incl | input | NUM_THR | Include the squashing instruction itself |
| ex_sq_mispred | input | NUM_THR | Squash caused by a branch mispredict |
| ex_sq_taken | input | NUM_THR | Branch outcome was taken |
| ex_sq_pc | input | NUM_THR*PC_W | Redirect PC |
| ex_sq_npc | input | NUM_THR*PC_W | Redirect next PC |
| ex_sq_upc | input | NUM_THR*UPC_W | Redirect micro-PC |
| cmt_pc | input | NUM_THR*PC_W | Saved commit PC used by squash-all |
| cmt_npc | input | NUM_THR*PC_W | Saved commit next PC |
| cmt_upc | input | NUM_THR*UPC_W | Saved commit micro-PC |
| rob_empty | input | NUM_THR | ROB holds nothing for the thread |
| rob_head_seq | input | NUM_THR*SEQ_W | Sequence number at the ROB head |
| rob_sq_done | input | NUM_THR | ROB has finished its squash walk |
| ren_vld | input | 1 | Renamed instruction offered |
| ren_tid | input | TID_W | Thread of the renamed instruction |
| ren_seq | input | SEQ_W | Sequence number of the renamed instruction |
| ren_squashed | input | 1 | Renamed instruction already marked squashed |
| rob_ins_vld | output | 1 | Write an entry into the ROB |
| rob_ins_tid | output | TID_W | Thread of the ROB write |
| rob_ins_seq | output | SEQ_W | Sequence number of the ROB write |
| rob_sq_vld | output | NUM_THR | Start a ROB squash |
| rob_sq_bound | output | NUM_THR*SEQ_W | Squash everything younger than this number |
| thr_state | output | NUM_THR*2 | Per thread: 0 running, 1 ROB squashing, 2 trap pending |
| bc_squash | output | NUM_THR | Broadcast: squash |
| bc_robsq | output | NUM_THR | Broadcast: ROB squash in progress |
| bc_mispred | output | NUM_THR | Broadcast: mispredict |
| bc_taken | output | NUM_THR | Broadcast: branch taken |
| bc_done_seq | output | NUM_THR*SEQ_W | Broadcast: done sequence number |
| bc_pc | output | NUM_THR*PC_W | Broadcast: redirect PC |
| bc_npc | output | NUM_THR*PC_W | Broadcast: redirect next PC |
| bc_upc | output | NUM_THR*UPC_W | Broadcast: redirect micro-PC |
| sq_conflict | output | NUM_THR | Trap and thread-context squash pending together |

## Verification
The bench drives collisions on one thread within a single cycle. An execute-stage squash is paired with a rename insert, and the insert must vanish while the youngest number keeps the boundary. A thread-context squash is paired with an execute-stage squash, and only the squash-all broadcast may appear, with mispredict at 0. A thread-context request lands on the edge where the trap timer expires, and two squash-all broadcasts must follow on consecutive cycles, with the conflict flag on the first. A scoreboard holds the broadcasts expected from these cases and compares them in order with the ones the block emits. A follow-up squash probes the youngest-inserted number after each collision.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    TS_RUN      = 2'd0,
    TS_ROBSQ    = 2'd1,
    TS_TRAPPEND = 2'd2
  } thr_state_e;
endpackage

// File: rtl/csq_trap_timer.sv
module csq_trap_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start && cnt_q == '0) begin
      cnt_q <= CW'(LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign fire = (cnt_q == CW'(1));

  AST_TRAP_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R9
endmodule

// File: rtl/csq_thread_ctl.sv
module csq_thread_ctl
  import csq_pkg::*;
#(
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int UPC_W    = 8,
  parameter int TRAP_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_gen,
  input  logic             tc_req,
  input  logic             ex_vld,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic             ex_mis,
  input  logic             ex_tkn,
  input  logic [PC_W-1:0]  ex_pc,
  input  logic [PC_W-1:0]  ex_npc,
  input  logic [UPC_W-1:0] ex_upc,
  input  logic [PC_W-1:0]  cmt_pc,
  input  logic [PC_W-1:0]  cmt_npc,
  input  logic [UPC_W-1:0] cmt_upc,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic             rob_done,
  input  logic             ins_hit,
  input  logic [SEQ_W-1:0] ins_seq,
  output logic             ins_ok,
  output logic [1:0]       state_o,
  output logic             sq_vld_o,
  output logic [SEQ_W-1:0] sq_bound_o,
  output logic             bc_squash_o,
  output logic             bc_robsq_o,
  output logic             bc_mis_o,
  output logic             bc_tkn_o,
  output logic [SEQ_W-1:0] bc_done_o,
  output logic [PC_W-1:0]  bc_pc_o,
  output logic [PC_W-1:0]  bc_npc_o,
  output logic [UPC_W-1:0] bc_upc_o,
  output logic             conflict_o
);
  thr_state_e       state_q;
  logic [SEQ_W-1:0] young_q;
  logic             tc_pend_q;

  logic             trap_fire;
  logic             tc_eff;
  logic             sq_all;
  logic             ex_acc;
  logic             trap_acc;
  logic [SEQ_W-1:0] ex_bound;
  logic [SEQ_W-1:0] all_bound;

  csq_trap_timer #(.LAT(TRAP_LAT)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (trap_acc),
    .fire  (trap_fire)
  );

  // Request arbitration: squash-all first, then execute squash, then trap.
  always_comb begin
    tc_eff    = tc_pend_q | tc_req;
    sq_all    = trap_fire | tc_eff;
    ex_acc    = ex_vld && (state_q != TS_TRAPPEND) && (ex_seq <= young_q) && !sq_all;
    trap_acc  = trap_gen && (state_q == TS_RUN) && !sq_all && !ex_acc;
    ex_bound  = ex_incl ? (ex_seq - SEQ_W'(1)) : ex_seq;
    all_bound = rob_empty ? '0 : (head_seq - SEQ_W'(1));
    ins_ok    = (state_q == TS_RUN) && !sq_all && !ex_acc && !trap_gen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TS_RUN;
      young_q   <= '0;
      tc_pend_q <= 1'b0;
    end else begin
      tc_pend_q <= tc_eff & trap_fire;
      if (sq_all)          young_q <= '0;
      else if (ex_acc)     young_q <= ex_bound;
      else if (ins_hit)    young_q <= ins_seq;
      if (sq_all || ex_acc)                          state_q <= TS_ROBSQ;
      else if (trap_acc)                             state_q <= TS_TRAPPEND;
      else if (state_q == TS_ROBSQ && rob_done)      state_q <= TS_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_vld_o    <= 1'b0;
      sq_bound_o  <= '0;
      bc_squash_o <= 1'b0;
      bc_robsq_o  <= 1'b0;
      bc_mis_o    <= 1'b0;
      bc_tkn_o    <= 1'b0;
      bc_done_o   <= '0;
      bc_pc_o     <= '0;
      bc_npc_o    <= '0;
      bc_upc_o    <= '0;
      conflict_o  <= 1'b0;
    end else begin
      sq_vld_o    <= sq_all | ex_acc;
      bc_squash_o <= sq_all | ex_acc;
      bc_robsq_o  <= sq_all | ex_acc | ((state_q == TS_ROBSQ) && !rob_done);
      bc_mis_o    <= ex_acc & ex_mis;
      bc_tkn_o    <= ex_acc & ex_tkn;
      conflict_o  <= trap_fire & tc_eff;
      if (sq_all) begin
        sq_bound_o <= all_bound;
        bc_done_o  <= all_bound;
        bc_pc_o    <= cmt_pc;
        bc_npc_o   <= cmt_npc;
        bc_upc_o   <= cmt_upc;
      end else if (ex_acc) begin
        sq_bound_o <= ex_bound;
        bc_done_o  <= ex_bound;
        bc_pc_o    <= ex_pc;
        bc_npc_o   <= ex_npc;
        bc_upc_o   <= ex_upc;
      end else begin
        sq_bound_o <= '0;
        bc_done_o  <= '0;
        bc_pc_o    <= '0;
        bc_npc_o   <= '0;
        bc_upc_o   <= '0;
      end
    end
  end

  assign state_o = state_q;

  AST_EX_TRAP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (state_q == TS_TRAPPEND && ex_vld && !sq_all) |=> !bc_squash_o); // R2
  AST_EX_TOO_YOUNG: assert property (@(posedge clk) disable iff (rst)
    (ex_vld && ex_seq > young_q && !sq_all) |=> !bc_squash_o); // R2
  AST_SQ_ENTERS_ROBSQ: assert property (@(posedge clk) disable iff (rst)
    bc_squash_o |-> (state_q == TS_ROBSQ)); // R4
  AST_SQ_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    bc_squash_o |-> bc_robsq_o); // R5
  AST_ALL_CLEARS_YOUNG: assert property (@(posedge clk) disable iff (rst)
    sq_all |=> (young_q == '0)); // R6
  AST_ALL_NO_MISPRED: assert property (@(posedge clk) disable iff (rst)
    sq_all |=> (bc_squash_o && !bc_mis_o)); // R11
  AST_DONE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    (state_q == TS_ROBSQ && rob_done && !sq_all && !ex_acc) |=> (state_q == TS_RUN && !bc_robsq_o)); // R7
  AST_CONFLICT_KEEPS_TC: assert property (@(posedge clk) disable iff (rst)
    (trap_fire && tc_eff) |=> (tc_pend_q && conflict_o)); // R10
endmodule

// File: rtl/csq_ins_gate.sv
module csq_ins_gate #(
  parameter int NUM_THR = 2,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ren_vld,
  input  logic [TID_W-1:0]   ren_tid,
  input  logic [SEQ_W-1:0]   ren_seq,
  input  logic               ren_squashed,
  input  logic [NUM_THR-1:0] ins_ok,
  output logic [NUM_THR-1:0] ins_hit,
  output logic               rob_ins_vld,
  output logic [TID_W-1:0]   rob_ins_tid,
  output logic [SEQ_W-1:0]   rob_ins_seq
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_hit
    assign ins_hit[t] = ren_vld && !ren_squashed && (ren_tid == TID_W'(t)) && ins_ok[t];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rob_ins_vld <= 1'b0;
      rob_ins_tid <= '0;
      rob_ins_seq <= '0;
    end else begin
      rob_ins_vld <= |ins_hit;
      rob_ins_tid <= ren_tid;
      rob_ins_seq <= ren_seq;
    end
  end
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
  parameter int NUM_THR  = 2,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int UPC_W    = 8,
  parameter int TRAP_LAT = 4,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_THR-1:0]       trap_gen,
  input  logic [NUM_THR-1:0]       tc_sq_req,
  input  logic [NUM_THR-1:0]       ex_sq_vld,
  input  logic [NUM_THR*SEQ_W-1:0] ex_sq_seq,
  input  logic [NUM_THR-1:0]       ex_sq_incl,
  input  logic [NUM_THR-1:0]       ex_sq_mispred,
  input  logic [NUM_THR-1:0]       ex_sq_taken,
  input  logic [NUM_THR*PC_W-1:0]  ex_sq_pc,
  input  logic [NUM_THR*PC_W-1:0]  ex_sq_npc,
  input  logic [NUM_THR*UPC_W-1:0] ex_sq_upc,
  input  logic [NUM_THR*PC_W-1:0]  cmt_pc,
  input  logic [NUM_THR*PC_W-1:0]  cmt_npc,
  input  logic [NUM_THR*UPC_W-1:0] cmt_upc,
  input  logic [NUM_THR-1:0]       rob_empty,
  input  logic [NUM_THR*SEQ_W-1:0] rob_head_seq,
  input  logic [NUM_THR-1:0]       rob_sq_done,
  input  logic                     ren_vld,
  input  logic [TID_W-1:0]         ren_tid,
  input  logic [SEQ_W-1:0]         ren_seq,
  input  logic                     ren_squashed,
  output logic                     rob_ins_vld,
  output logic [TID_W-1:0]         rob_ins_tid,
  output logic [SEQ_W-1:0]         rob_ins_seq,
  output logic [NUM_THR-1:0]       rob_sq_vld,
  output logic [NUM_THR*SEQ_W-1:0] rob_sq_bound,
  output logic [NUM_THR*2-1:0]     thr_state,
  output logic [NUM_THR-1:0]       bc_squash,
  output logic [NUM_THR-1:0]       bc_robsq,
  output logic [NUM_THR-1:0]       bc_mispred,
  output logic [NUM_THR-1:0]       bc_taken,
  output logic [NUM_THR*SEQ_W-1:0] bc_done_seq,
  output logic [NUM_THR*PC_W-1:0]  bc_pc,
  output logic [NUM_THR*PC_W-1:0]  bc_npc,
  output logic [NUM_THR*UPC_W-1:0] bc_upc,
  output logic [NUM_THR-1:0]       sq_conflict
);
  logic [NUM_THR-1:0] ins_ok;
  logic [NUM_THR-1:0] ins_hit;

  csq_ins_gate #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_gate (
    .clk          (clk),
    .rst          (rst),
    .ren_vld      (ren_vld),
    .ren_tid      (ren_tid),
    .ren_seq      (ren_seq),
    .ren_squashed (ren_squashed),
    .ins_ok       (ins_ok),
    .ins_hit      (ins_hit),
    .rob_ins_vld  (rob_ins_vld),
    .rob_ins_tid  (rob_ins_tid),
    .rob_ins_seq  (rob_ins_seq)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    csq_thread_ctl #(
      .SEQ_W(SEQ_W), .PC_W(PC_W), .UPC_W(UPC_W), .TRAP_LAT(TRAP_LAT)
    ) u_thr (
      .clk         (clk),
      .rst         (rst),
      .trap_gen    (trap_gen[t]),
      .tc_req      (tc_sq_req[t]),
      .ex_vld      (ex_sq_vld[t]),
      .ex_seq      (ex_sq_seq[t*SEQ_W +: SEQ_W]),
      .ex_incl     (ex_sq_incl[t]),
      .ex_mis      (ex_sq_mispred[t]),
      .ex_tkn      (ex_sq_taken[t]),
      .ex_pc       (ex_sq_pc[t*PC_W +: PC_W]),
      .ex_npc      (ex_sq_npc[t*PC_W +: PC_W]),
      .ex_upc      (ex_sq_upc[t*UPC_W +: UPC_W]),
      .cmt_pc      (cmt_pc[t*PC_W +: PC_W]),
      .cmt_npc     (cmt_npc[t*PC_W +: PC_W]),
      .cmt_upc     (cmt_upc[t*UPC_W +: UPC_W]),
      .rob_empty   (rob_empty[t]),
      .head_seq    (rob_head_seq[t*SEQ_W +: SEQ_W]),
      .rob_done    (rob_sq_done[t]),
      .ins_hit     (ins_hit[t]),
      .ins_seq     (ren_seq),
      .ins_ok      (ins_ok[t]),
      .state_o     (thr_state[t*2 +: 2]),
      .sq_vld_o    (rob_sq_vld[t]),
      .sq_bound_o  (rob_sq_bound[t*SEQ_W +: SEQ_W]),
      .bc_squash_o (bc_squash[t]),
      .bc_robsq_o  (bc_robsq[t]),
      .bc_mis_o    (bc_mispred[t]),
      .bc_tkn_o    (bc_taken[t]),
      .bc_done_o   (bc_done_seq[t*SEQ_W +: SEQ_W]),
      .bc_pc_o     (bc_pc[t*PC_W +: PC_W]),
      .bc_npc_o    (bc_npc[t*PC_W +: PC_W]),
      .bc_upc_o    (bc_upc[t*UPC_W +: UPC_W]),
      .conflict_o  (sq_conflict[t])
    );
  end

  AST_NO_INS_ON_SQ: assert property (@(posedge clk) disable iff (rst)
    rob_ins_vld |-> !rob_sq_vld[rob_ins_tid]); // R8
endmodule

// File: tb/commit_squash_ctrl_tb_top.sv
`timescale 1ns/1ps
module commit_squash_ctrl_tb_top;
  localparam int NT = 2;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int UW = 8;
  localparam int L  = 4;
  localparam int TW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NT-1:0]    trap_gen, tc_sq_req, ex_sq_vld, ex_sq_incl, ex_sq_mispred, ex_sq_taken;
  logic [NT*SW-1:0] ex_sq_seq, rob_head_seq;
  logic [NT*PW-1:0] ex_sq_pc, ex_sq_npc, cmt_pc, cmt_npc;
  logic [NT*UW-1:0] ex_sq_upc, cmt_upc;
  logic [NT-1:0]    rob_empty, rob_sq_done;
  logic             ren_vld, ren_squashed;
  logic [TW-1:0]    ren_tid;
  logic [SW-1:0]    ren_seq;
  logic             rob_ins_vld;
  logic [TW-1:0]    rob_ins_tid;
  logic [SW-1:0]    rob_ins_seq;
  logic [NT-1:0]    rob_sq_vld, bc_squash, bc_robsq, bc_mispred, bc_taken, sq_conflict;
  logic [NT*SW-1:0] rob_sq_bound, bc_done_seq;
  logic [NT*2-1:0]  thr_state;
  logic [NT*PW-1:0] bc_pc, bc_npc;
  logic [NT*UW-1:0] bc_upc;

  commit_squash_ctrl #(.NUM_THR(NT), .SEQ_W(SW), .PC_W(PW), .UPC_W(UW), .TRAP_LAT(L)) dut_i (
    .clk(clk), .rst(rst), .trap_gen(trap_gen), .tc_sq_req(tc_sq_req),
    .ex_sq_vld(ex_sq_vld), .ex_sq_seq(ex_sq_seq), .ex_sq_incl(ex_sq_incl),
    .ex_sq_mispred(ex_sq_mispred), .ex_sq_taken(ex_sq_taken), .ex_sq_pc(ex_sq_pc),
    .ex_sq_npc(ex_sq_npc), .ex_sq_upc(ex_sq_upc), .cmt_pc(cmt_pc), .cmt_npc(cmt_npc),
    .cmt_upc(cmt_upc), .rob_empty(rob_empty), .rob_head_seq(rob_head_seq),
    .rob_sq_done(rob_sq_done), .ren_vld(ren_vld), .ren_tid(ren_tid), .ren_seq(ren_seq),
    .ren_squashed(ren_squashed), .rob_ins_vld(rob_ins_vld), .rob_ins_tid(rob_ins_tid),
    .rob_ins_seq(rob_ins_seq), .rob_sq_vld(rob_sq_vld), .rob_sq_bound(rob_sq_bound),
    .thr_state(thr_state), .bc_squash(bc_squash), .bc_robsq(bc_robsq),
    .bc_mispred(bc_mispred), .bc_taken(bc_taken), .bc_done_seq(bc_done_seq),
    .bc_pc(bc_pc), .bc_npc(bc_npc), .bc_upc(bc_upc), .sq_conflict(sq_conflict)
  );

  typedef struct {
    int     tid;
    longint done;
    bit     mis;
    bit     tkn;
    longint pc;
    longint npc;
    longint upc;
    string  req;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_err = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(int t, longint done, bit mis, bit tkn, longint pc, longint npc, longint upc, string req);
    exp_t e;
    e.tid = t; e.done = done; e.mis = mis; e.tkn = tkn;
    e.pc = pc; e.npc = npc; e.upc = upc; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: every broadcast squash is matched against the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      for (int t = 0; t < NT; t++) begin
        if (bc_squash[t]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected squash on thread", t, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tid == t, {e.req, " thread"}, t, e.tid);
            chk(bc_done_seq[t*SW +: SW] == SW'(e.done), {e.req, " done seq"}, bc_done_seq[t*SW +: SW], e.done);
            chk(rob_sq_vld[t] && rob_sq_bound[t*SW +: SW] == SW'(e.done), "R4 rob bound", rob_sq_bound[t*SW +: SW], e.done);
            chk(bc_robsq[t], {e.req, " robsq flag"}, bc_robsq[t], 1);
            chk(bc_mispred[t] == e.mis && bc_taken[t] == e.tkn, {e.req, " mispred/taken"},
                {bc_mispred[t], bc_taken[t]}, {e.mis, e.tkn});
            chk(bc_pc[t*PW +: PW] == PW'(e.pc) && bc_npc[t*PW +: PW] == PW'(e.npc) &&
                bc_upc[t*UW +: UW] == UW'(e.upc), {e.req, " redirect pc"}, bc_pc[t*PW +: PW], e.pc);
          end
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr();
    trap_gen = '0; tc_sq_req = '0; ex_sq_vld = '0; ex_sq_incl = '0;
    ex_sq_mispred = '0; ex_sq_taken = '0; ren_vld = 1'b0; ren_squashed = 1'b0;
    rob_sq_done = '0;
  endtask

  task automatic ex_req(int t, int seq, bit incl, bit mis, bit tkn, int pc, int npc, int upc);
    ex_sq_vld[t] = 1'b1;
    ex_sq_seq[t*SW +: SW] = SW'(seq);
    ex_sq_incl[t] = incl;
    ex_sq_mispred[t] = mis;
    ex_sq_taken[t] = tkn;
    ex_sq_pc[t*PW +: PW] = PW'(pc);
    ex_sq_npc[t*PW +: PW] = PW'(npc);
    ex_sq_upc[t*UW +: UW] = UW'(upc);
  endtask

  task automatic ren(int t, int seq, bit sqd);
    ren_vld = 1'b1; ren_tid = TW'(t); ren_seq = SW'(seq); ren_squashed = sqd;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clr();
    ren_tid = '0; ren_seq = '0; ex_sq_seq = '0; ex_sq_pc = '0; ex_sq_npc = '0; ex_sq_upc = '0;
    cmt_pc  = {32'h0000_2000, 32'h0000_1000};
    cmt_npc = {32'h0000_2004, 32'h0000_1004};
    cmt_upc = {8'd7, 8'd2};
    rob_empty = '0;
    rob_head_seq = {16'd25, 16'd5};
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk(thr_state == '0, "R1 state", thr_state, 0);
    chk(bc_squash == '0 && bc_robsq == '0 && rob_sq_vld == '0, "R1 squash outputs", {bc_squash, bc_robsq}, 0);
    chk(!rob_ins_vld && sq_conflict == '0, "R1 insert/conflict", rob_ins_vld, 0);

    // R8 inserts into thread 0
    ren(0, 10, 0); cyc(); clr();
    chk(rob_ins_vld && rob_ins_tid == 0 && rob_ins_seq == 10, "R8 insert seq", rob_ins_seq, 10);
    ren(0, 11, 0); cyc(); clr();
    chk(rob_ins_vld && rob_ins_seq == 11, "R8 insert seq", rob_ins_seq, 11);

    // R2 squash younger than youngest is ignored
    ex_req(0, 12, 0, 1, 1, 'h1100, 'h1104, 3); cyc(); clr();
    chk(bc_squash[0] == 0, "R2 younger squash ignored", bc_squash[0], 0);
    chk(thr_state[1:0] == 0, "R2 state unchanged", thr_state[1:0], 0);

    // R3/R5 accepted execute squash without include-self
    push(0, 11, 1, 1, 'h1100, 'h1104, 3, "R5");
    ex_req(0, 11, 0, 1, 1, 'h1100, 'h1104, 3); cyc(); clr();
    chk(thr_state[1:0] == 1, "R4 state robsq", thr_state[1:0], 1);

    // R7 flag re-sent; R8 insert blocked while squashing
    ren(0, 12, 0); cyc(); clr();
    chk(!rob_ins_vld, "R8 insert blocked in robsq", rob_ins_vld, 0);
    chk(bc_robsq[0] && !bc_squash[0], "R7 robsq re-sent", bc_robsq[0], 1);
    rob_sq_done[0] = 1'b1; cyc(); clr();
    chk(thr_state[1:0] == 0 && !bc_robsq[0], "R7 back to running", thr_state[1:0], 0);

    // R3 include-self boundary
    push(0, 10, 0, 0, 'h1200, 'h1204, 1, "R3");
    ex_req(0, 11, 1, 0, 0, 'h1200, 'h1204, 1); cyc(); clr();
    chk(rob_sq_bound[SW-1:0] == 10, "R3 include-self bound", rob_sq_bound[SW-1:0], 10);
    rob_sq_done[0] = 1'b1; cyc(); clr();

    // R4 youngest took the boundary (10): seq 11 now rejected
    ex_req(0, 11, 0, 0, 0, 0, 0, 0); cyc(); clr();
    chk(bc_squash[0] == 0, "R4 youngest equals boundary", bc_squash[0], 0);

    // R8 same-cycle insert and squash on thread 1
    ren(1, 30, 0); cyc(); clr();
    chk(rob_ins_vld && rob_ins_tid == 1 && rob_ins_seq == 30, "R8 insert thread1", rob_ins_seq, 30);
    push(1, 29, 1, 0, 'h2200, 'h2204, 4, "R5");
    ex_req(1, 30, 1, 1, 0, 'h2200, 'h2204, 4); ren(1, 31, 0); cyc(); clr();
    chk(!rob_ins_vld, "R8 insert dropped on squash cycle", rob_ins_vld, 0);
    rob_sq_done[1] = 1'b1; cyc(); clr();
    ex_req(1, 30, 0, 0, 0, 0, 0, 0); cyc(); clr();
    chk(bc_squash[1] == 0, "R8 dropped insert left youngest", bc_squash[1], 0);
    ren(0, 50, 1); cyc(); clr();
    chk(!rob_ins_vld, "R8 squashed-marked insert", rob_ins_vld, 0);

    // R6/R11 thread-context squash with a colliding execute squash
    push(1, 24, 0, 0, 'h2000, 'h2004, 7, "R11");
    tc_sq_req[1] = 1'b1; ex_req(1, 0, 0, 1, 1, 'h3000, 'h3004, 9); cyc(); clr();
    chk(thr_state[3:2] == 1, "R6 squash-all state", thr_state[3:2], 1);
    rob_sq_done[1] = 1'b1; cyc(); clr();
    ex_req(1, 1, 0, 0, 0, 0, 0, 0); cyc(); clr();
    chk(bc_squash[1] == 0, "R6 youngest cleared", bc_squash[1], 0);

    // R6 empty ROB gives boundary 0
    rob_empty[1] = 1'b1;
    push(1, 0, 0, 0, 'h2000, 'h2004, 7, "R6");
    tc_sq_req[1] = 1'b1; cyc(); clr();
    rob_empty[1] = 1'b0;
    rob_sq_done[1] = 1'b1; cyc(); clr();

    // R9 trap timer on thread 0, R2 execute squash ignored while trap pending
    trap_gen[0] = 1'b1; cyc(); clr();
    chk(thr_state[1:0] == 2, "R9 trap pending state", thr_state[1:0], 2);
    for (int i = 1; i < L; i++) begin
      if (i == 1) ex_req(0, 5, 0, 1, 0, 'h4000, 'h4004, 0);
      cyc(); clr();
      chk(bc_squash[0] == 0, "R9 no squash before latency", bc_squash[0], 0);
    end
    push(0, 4, 0, 0, 'h1000, 'h1004, 2, "R9");
    cyc();
    chk(bc_squash[0] && thr_state[1:0] == 1, "R9 trap squash at latency", bc_squash[0], 1);
    rob_sq_done[0] = 1'b1; cyc(); clr();

    // R10 trap and thread-context on the same edge
    trap_gen[1] = 1'b1; cyc(); clr();
    for (int i = 1; i < L; i++) cyc();
    push(1, 24, 0, 0, 'h2000, 'h2004, 7, "R10");
    tc_sq_req[1] = 1'b1; cyc(); clr();
    chk(sq_conflict[1] == 1, "R10 conflict flagged", sq_conflict[1], 1);
    push(1, 24, 0, 0, 'h2000, 'h2004, 7, "R10");
    cyc();
    chk(bc_squash[1] == 1 && sq_conflict[1] == 0, "R10 tc squash follows", bc_squash[1], 1);
    rob_sq_done[1] = 1'b1; cyc(); clr();
    cyc(); cyc();
    chk(exp_q.size() == 0, "R5 all expected broadcasts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule